// File: doc/BRIEF.md
# Load-word address and exception unit

This block executes one immediate-offset word load for a 32-bit soft processor. It forms an effective address from a base register value and a 16-bit immediate. An earlier prefix instruction may supply the upper half of that immediate. The block presents the address to an external translation check and to a simple memory read port. It then either commits the returned word to the destination register or takes an exception.

The block checks three faults in a fixed priority: a translation miss, an access-protection fault and a misaligned word address. Each fault has its own cause code and its own side effects on the exception status and machine status registers. The user-mode and virtual-mode bits are saved and cleared on the two memory-management faults.

A parameter selects between a fast variant and an area variant. The fast variant checks and issues the read in the issue cycle. The area variant registers the address first and so takes one more cycle. Loads can be issued back to back in both variants.

Top module: `ldw_exec_unit`

## Requirements
- R1: An instruction with issue_valid=1 and issue_opcode=6'b111010 is a word load. Its address, shown on acc_addr, is ra_value plus issue_imm sign-extended to 32 bits.
- R2: An instruction with issue_opcode equal to PREFIX_OP (default 6'b101100) stores its issue_imm. The next instruction issued, of any opcode, consumes it. If that instruction is a load, the stored value replaces the sign extension as address bits 31:16. The stored value is then discarded, so a later load sign-extends again.
- R3: xlat_hit=0 while msr_vm=1 is a translation fault with esr_cause=5'b10010. It outranks every other fault. When msr_vm=0, xlat_hit is ignored.
- R4: If no translation fault applies, xlat_protect=1 with msr_um=1 and msr_vm=1 is a protection fault. It gives esr_cause=5'b10000, with esr_diz_we=1 and esr_diz=0. It outranks misalignment. If either mode bit is 0, xlat_protect is ignored.
- R5: On a translation or protection fault, msr_we=1 and msr_ums_next and msr_vms_next equal the msr_um and msr_vm of the access. msr_um_next and msr_vm_next are 0. On any other outcome, msr_we=0.
- R6: Otherwise, if acc_addr[1:0] is not 2'b00, the block takes an alignment fault. It gives esr_cause=5'b00001, esr_word=1 and esr_reg equal to the destination register number.
- R7: Each faulting load raises exc_valid for exactly one cycle, with esr_store=0 and rf_we=0. No mem_req is issued for that load.
- R8: A load with no fault asserts mem_req and then writes mem_rdata to register issue_rd through rf_we, rf_waddr and rf_wdata.
- R9: A load whose destination is register 0 never asserts rf_we.
- R10: With AREA_OPT=0, mem_req and acc_addr are valid in the issue cycle and the result appears one cycle later. With AREA_OPT=1, mem_req and acc_addr are valid one cycle after issue and the result appears two cycles after issue. mem_rdata is expected one cycle after mem_req in both variants.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue_valid | input | 1 | An instruction is issued this cycle |
| issue_opcode | input | 6 | Major opcode of the issued instruction |
| issue_rd | input | 5 | Destination register number |
| issue_imm | input | 16 | Immediate field |
| ra_value | input | 32 | Base register value |
| msr_um | input | 1 | Current user-mode bit |
| msr_vm | input | 1 | Current virtual-mode bit |
| xlat_hit | input | 1 | Translation found for acc_addr |
| xlat_protect | input | 1 | Access to acc_addr is protected |
| acc_addr | output | 32 | Address under check and read |
| mem_req | output | 1 | Memory read request |
| mem_rdata | input | 32 | Read data, one cycle after mem_req |
| rf_we | output | 1 | Register write enable |
| rf_waddr | output | 5 | Register write index |
| rf_wdata | output | 32 | Register write data |
| exc_valid | output | 1 | Exception taken this cycle |
| esr_cause | output | 5 | Exception cause code |
| esr_store | output | 1 | Store flag, 0 for loads |
| esr_word | output | 1 | Word-access flag of an alignment fault |
| esr_reg | output | 5 | Register number of an alignment fault |
| esr_diz_we | output | 1 | Zone-detail bit write enable |
| esr_diz | output | 1 | Zone-detail bit value |
| msr_we | output | 1 | Mode bits update enable |
| msr_um_next | output | 1 | New user-mode bit |
| msr_vm_next | output | 1 | New virtual-mode bit |
| msr_ums_next | output | 1 | New saved user-mode bit |
| msr_vms_next | output | 1 | New saved virtual-mode bit |

## Verification
A stale prefix register shows up as a wrong upper half on acc_addr at the next load, in that load's address cycle. A wrong fault classification held in the result stage shows up one cycle after the check as the wrong cause code, a missing or extra exc_valid pulse, or a register write where none belongs. The saved mode bits reach msr_*_next in that same result cycle. A pipeline stage slipped by one cycle moves mem_req and the result away from the cycles given in R10, and the bench samples exactly those cycles in both variants.

// File: rtl/ldw_pkg.sv
package ldw_pkg;

    localparam int DATA_W    = 32;
    localparam int IMM_W     = 16;
    localparam int HI_W      = DATA_W - IMM_W;
    localparam int RIDX_W    = 5;
    localparam int OPC_W     = 6;
    localparam int CAUSE_W   = 5;
    localparam int ALIGN_LSB = $clog2(DATA_W / 8);

    localparam logic [OPC_W-1:0]   OPC_LOADW   = 6'b111010;
    localparam logic [CAUSE_W-1:0] CAUSE_XLAT  = 5'b10010;
    localparam logic [CAUSE_W-1:0] CAUSE_PROT  = 5'b10000;
    localparam logic [CAUSE_W-1:0] CAUSE_ALIGN = 5'b00001;

    typedef enum logic [1:0] {
        FLT_NONE  = 2'd0,
        FLT_XLAT  = 2'd1,
        FLT_PROT  = 2'd2,
        FLT_ALIGN = 2'd3
    } fault_e;

    typedef struct packed {
        logic              valid;
        logic [RIDX_W-1:0] rd;
        logic [DATA_W-1:0] addr;
    } ld_req_t;

    typedef struct packed {
        logic              valid;
        logic [RIDX_W-1:0] rd;
        fault_e            fault;
        logic              um;
        logic              vm;
    } ld_res_t;

    // Fixed priority: translation, then protection, then alignment.
    function automatic fault_e classify(
        input logic [ALIGN_LSB-1:0] low_bits,
        input logic                 hit,
        input logic                 prot,
        input logic                 um,
        input logic                 vm
    );
        if (vm && !hit)
            return FLT_XLAT;
        else if (prot && um && vm)
            return FLT_PROT;
        else if (low_bits != '0)
            return FLT_ALIGN;
        else
            return FLT_NONE;
    endfunction

    function automatic logic [CAUSE_W-1:0] cause_of(input fault_e f);
        case (f)
            FLT_XLAT:  return CAUSE_XLAT;
            FLT_PROT:  return CAUSE_PROT;
            FLT_ALIGN: return CAUSE_ALIGN;
            default:   return '0;
        endcase
    endfunction

endpackage

// File: rtl/ldw_addr_gen.sv
module ldw_addr_gen
    import ldw_pkg::*;
#(
    parameter logic [OPC_W-1:0] PREFIX_OP = 6'b101100
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              issue_valid,
    input  logic [OPC_W-1:0]  issue_opcode,
    input  logic [RIDX_W-1:0] issue_rd,
    input  logic [IMM_W-1:0]  issue_imm,
    input  logic [DATA_W-1:0] ra_value,
    output ld_req_t           req
);

    logic            pfx_valid_q;
    logic [HI_W-1:0] pfx_hi_q;
    logic            is_prefix;
    logic [HI_W-1:0] upper;

    assign is_prefix = issue_opcode == PREFIX_OP;

    // Held upper half lives for exactly one following instruction.
    always_ff @(posedge clk) begin
        if (rst) begin
            pfx_valid_q <= 1'b0;
            pfx_hi_q    <= '0;
        end else if (issue_valid) begin
            pfx_valid_q <= is_prefix;
            if (is_prefix)
                pfx_hi_q <= HI_W'(issue_imm);
        end
    end

    assign upper = pfx_valid_q ? pfx_hi_q : {HI_W{issue_imm[IMM_W-1]}};

    always_comb begin
        req.valid = issue_valid && (issue_opcode == OPC_LOADW);
        req.rd    = issue_rd;
        req.addr  = ra_value + {upper, issue_imm};
    end

endmodule

// File: rtl/ldw_fault_chk.sv
module ldw_fault_chk
    import ldw_pkg::*;
(
    input  ld_req_t req,
    input  logic    xlat_hit,
    input  logic    xlat_protect,
    input  logic    msr_um,
    input  logic    msr_vm,
    output ld_res_t res,
    output logic    mem_req
);

    fault_e kind;

    assign kind = classify(req.addr[ALIGN_LSB-1:0], xlat_hit, xlat_protect,
                           msr_um, msr_vm);

    always_comb begin
        res.valid = req.valid;
        res.rd    = req.rd;
        res.fault = kind;
        res.um    = msr_um;
        res.vm    = msr_vm;
    end

    // No read leaves the block once any fault is known.
    assign mem_req = req.valid && (kind == FLT_NONE);

endmodule

// File: rtl/ldw_commit.sv
module ldw_commit
    import ldw_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  ld_res_t            res_d,
    input  logic [DATA_W-1:0]  mem_rdata,
    output logic               rf_we,
    output logic [RIDX_W-1:0]  rf_waddr,
    output logic [DATA_W-1:0]  rf_wdata,
    output logic               exc_valid,
    output logic [CAUSE_W-1:0] esr_cause,
    output logic               esr_store,
    output logic               esr_word,
    output logic [RIDX_W-1:0]  esr_reg,
    output logic               esr_diz_we,
    output logic               esr_diz,
    output logic               msr_we,
    output logic               msr_um_next,
    output logic               msr_vm_next,
    output logic               msr_ums_next,
    output logic               msr_vms_next
);

    ld_res_t q;
    logic    ok;
    logic    mmu_fault;

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '{valid: 1'b0, rd: '0, fault: FLT_NONE, um: 1'b0, vm: 1'b0};
        end else begin
            q <= res_d;
        end
    end

    assign ok        = q.valid && (q.fault == FLT_NONE);
    assign mmu_fault = q.valid && (q.fault == FLT_XLAT || q.fault == FLT_PROT);

    // Register 0 is never written.
    assign rf_we    = ok && (q.rd != '0);
    assign rf_waddr = q.rd;
    assign rf_wdata = mem_rdata;

    assign exc_valid  = q.valid && (q.fault != FLT_NONE);
    assign esr_cause  = exc_valid ? cause_of(q.fault) : '0;
    assign esr_store  = 1'b0;
    assign esr_word   = q.valid && (q.fault == FLT_ALIGN);
    assign esr_reg    = esr_word ? q.rd : '0;
    assign esr_diz_we = q.valid && (q.fault == FLT_PROT);
    assign esr_diz    = 1'b0;

    assign msr_we       = mmu_fault;
    assign msr_um_next  = 1'b0;
    assign msr_vm_next  = 1'b0;
    assign msr_ums_next = mmu_fault && q.um;
    assign msr_vms_next = mmu_fault && q.vm;

endmodule

// File: rtl/ldw_exec_unit.sv
module ldw_exec_unit
    import ldw_pkg::*;
#(
    parameter bit               AREA_OPT  = 1'b0,
    parameter logic [OPC_W-1:0] PREFIX_OP = 6'b101100
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               issue_valid,
    input  logic [OPC_W-1:0]   issue_opcode,
    input  logic [RIDX_W-1:0]  issue_rd,
    input  logic [IMM_W-1:0]   issue_imm,
    input  logic [DATA_W-1:0]  ra_value,
    input  logic               msr_um,
    input  logic               msr_vm,
    input  logic               xlat_hit,
    input  logic               xlat_protect,
    output logic [DATA_W-1:0]  acc_addr,
    output logic               mem_req,
    input  logic [DATA_W-1:0]  mem_rdata,
    output logic               rf_we,
    output logic [RIDX_W-1:0]  rf_waddr,
    output logic [DATA_W-1:0]  rf_wdata,
    output logic               exc_valid,
    output logic [CAUSE_W-1:0] esr_cause,
    output logic               esr_store,
    output logic               esr_word,
    output logic [RIDX_W-1:0]  esr_reg,
    output logic               esr_diz_we,
    output logic               esr_diz,
    output logic               msr_we,
    output logic               msr_um_next,
    output logic               msr_vm_next,
    output logic               msr_ums_next,
    output logic               msr_vms_next
);

    ld_req_t req_c;
    ld_req_t req_s;
    ld_res_t res_c;

    ldw_addr_gen #(
        .PREFIX_OP(PREFIX_OP)
    ) u_addr (
        .clk         (clk),
        .rst         (rst),
        .issue_valid (issue_valid),
        .issue_opcode(issue_opcode),
        .issue_rd    (issue_rd),
        .issue_imm   (issue_imm),
        .ra_value    (ra_value),
        .req         (req_c)
    );

    generate
        if (AREA_OPT) begin : g_area
            ld_req_t stage_q;
            always_ff @(posedge clk) begin
                if (rst)
                    stage_q <= '{valid: 1'b0, rd: '0, addr: '0};
                else
                    stage_q <= req_c;
            end
            assign req_s = stage_q;
        end else begin : g_fast
            assign req_s = req_c;
        end
    endgenerate

    assign acc_addr = req_s.addr;

    ldw_fault_chk u_chk (
        .req         (req_s),
        .xlat_hit    (xlat_hit),
        .xlat_protect(xlat_protect),
        .msr_um      (msr_um),
        .msr_vm      (msr_vm),
        .res         (res_c),
        .mem_req     (mem_req)
    );

    ldw_commit u_commit (
        .clk         (clk),
        .rst         (rst),
        .res_d       (res_c),
        .mem_rdata   (mem_rdata),
        .rf_we       (rf_we),
        .rf_waddr    (rf_waddr),
        .rf_wdata    (rf_wdata),
        .exc_valid   (exc_valid),
        .esr_cause   (esr_cause),
        .esr_store   (esr_store),
        .esr_word    (esr_word),
        .esr_reg     (esr_reg),
        .esr_diz_we  (esr_diz_we),
        .esr_diz     (esr_diz),
        .msr_we      (msr_we),
        .msr_um_next (msr_um_next),
        .msr_vm_next (msr_vm_next),
        .msr_ums_next(msr_ums_next),
        .msr_vms_next(msr_vms_next)
    );

endmodule

// File: rtl/ldw_exec_checker.sv
module ldw_exec_checker
    import ldw_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               mem_req,
    input logic               exc_valid,
    input logic               rf_we,
    input logic [RIDX_W-1:0]  rf_waddr,
    input logic [CAUSE_W-1:0] esr_cause,
    input logic               esr_store,
    input logic               esr_word,
    input logic               esr_diz_we,
    input logic               msr_we,
    input logic               msr_um_next,
    input logic               msr_vm_next
);

    // R7: a fault never writes the register file.
    p_no_write_on_fault_r7: assert property (@(posedge clk) disable iff (rst)
        exc_valid |-> !rf_we);

    // R7: a load that reaches memory does not fault on the next cycle.
    p_req_then_no_exc_r7: assert property (@(posedge clk) disable iff (rst)
        mem_req |=> !exc_valid);

    // R7: the store flag stays clear on load faults.
    p_store_clear_r7: assert property (@(posedge clk) disable iff (rst)
        exc_valid |-> !esr_store);

    // R5: a mode update clears both live mode bits and comes with an exception.
    p_mode_clear_r5: assert property (@(posedge clk) disable iff (rst)
        msr_we |-> (exc_valid && !msr_um_next && !msr_vm_next));

    // R9: register 0 is never written.
    p_no_r0_write_r9: assert property (@(posedge clk) disable iff (rst)
        rf_we |-> (rf_waddr != '0));

    // R6: the word flag only accompanies the alignment cause.
    p_align_code_r6: assert property (@(posedge clk) disable iff (rst)
        esr_word |-> (exc_valid && esr_cause == CAUSE_ALIGN));

    // R4: the zone-detail write only accompanies the protection cause.
    p_diz_prot_r4: assert property (@(posedge clk) disable iff (rst)
        esr_diz_we |-> (msr_we && esr_cause == CAUSE_PROT));

endmodule

bind ldw_exec_unit ldw_exec_checker u_ldw_exec_checker (
    .clk       (clk),
    .rst       (rst),
    .mem_req   (mem_req),
    .exc_valid (exc_valid),
    .rf_we     (rf_we),
    .rf_waddr  (rf_waddr),
    .esr_cause (esr_cause),
    .esr_store (esr_store),
    .esr_word  (esr_word),
    .esr_diz_we(esr_diz_we),
    .msr_we    (msr_we),
    .msr_um_next (msr_um_next),
    .msr_vm_next (msr_vm_next)
);

// File: tb/test_ldw_exec_unit.sv
module test_ldw_exec_unit;

    localparam logic [5:0] OP_LOAD   = 6'b111010;
    localparam logic [5:0] OP_PREFIX = 6'b101100;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        issue_valid = 1'b0;
    logic [5:0]  issue_opcode = '0;
    logic [4:0]  issue_rd = '0;
    logic [15:0] issue_imm = '0;
    logic [31:0] ra_value = '0;
    logic        msr_um = 1'b0, msr_vm = 1'b0;
    logic        xlat_hit = 1'b1, xlat_protect = 1'b0;

    // Outputs of the fast variant (suffix 0) and the area variant (suffix 1).
    logic [31:0] addr0, addr1, rdata0, rdata1, wdata0, wdata1;
    logic        req0, req1, we0, we1, exc0, exc1, store0, store1, word0, word1;
    logic        dizwe0, dizwe1, diz0, diz1, mwe0, mwe1;
    logic        um0, um1, vm0, vm1, ums0, ums1, vms0, vms1;
    logic [4:0]  waddr0, waddr1, cause0, cause1, ereg0, ereg1;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    ldw_exec_unit #(.AREA_OPT(1'b0)) i_ldw_exec_unit (
        .clk(clk), .rst(rst), .issue_valid(issue_valid), .issue_opcode(issue_opcode),
        .issue_rd(issue_rd), .issue_imm(issue_imm), .ra_value(ra_value),
        .msr_um(msr_um), .msr_vm(msr_vm), .xlat_hit(xlat_hit), .xlat_protect(xlat_protect),
        .acc_addr(addr0), .mem_req(req0), .mem_rdata(rdata0),
        .rf_we(we0), .rf_waddr(waddr0), .rf_wdata(wdata0),
        .exc_valid(exc0), .esr_cause(cause0), .esr_store(store0), .esr_word(word0),
        .esr_reg(ereg0), .esr_diz_we(dizwe0), .esr_diz(diz0),
        .msr_we(mwe0), .msr_um_next(um0), .msr_vm_next(vm0),
        .msr_ums_next(ums0), .msr_vms_next(vms0)
    );

    ldw_exec_unit #(.AREA_OPT(1'b1)) i_ldw_exec_unit_a1 (
        .clk(clk), .rst(rst), .issue_valid(issue_valid), .issue_opcode(issue_opcode),
        .issue_rd(issue_rd), .issue_imm(issue_imm), .ra_value(ra_value),
        .msr_um(msr_um), .msr_vm(msr_vm), .xlat_hit(xlat_hit), .xlat_protect(xlat_protect),
        .acc_addr(addr1), .mem_req(req1), .mem_rdata(rdata1),
        .rf_we(we1), .rf_waddr(waddr1), .rf_wdata(wdata1),
        .exc_valid(exc1), .esr_cause(cause1), .esr_store(store1), .esr_word(word1),
        .esr_reg(ereg1), .esr_diz_we(dizwe1), .esr_diz(diz1),
        .msr_we(mwe1), .msr_um_next(um1), .msr_vm_next(vm1),
        .msr_ums_next(ums1), .msr_vms_next(vms1)
    );

    function automatic logic [31:0] mem_word(input logic [31:0] a);
        return {a[15:0], ~a[31:16]} ^ 32'h5A3C_0F96;
    endfunction

    // Memory model: data one cycle after the request.
    always_ff @(posedge clk) begin
        if (req0) rdata0 <= mem_word(addr0);
        if (req1) rdata1 <= mem_word(addr1);
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Expected result of the load in flight.
    logic [31:0] e_addr;
    logic [4:0]  e_rd;
    logic [1:0]  e_kind;    // 0 none, 1 translation, 2 protection, 3 alignment
    logic        e_um, e_vm;

    task automatic check_result(input string v, input logic exc, input logic [4:0] cause,
                                input logic we, input logic [4:0] wa, input logic [31:0] wd,
                                input logic mwe, input logic ums, input logic vms,
                                input logic um, input logic vm, input logic word,
                                input logic [4:0] ereg, input logic dizwe, input logic diz,
                                input logic store);
        logic [4:0] ecause;
        ecause = (e_kind == 2'd1) ? 5'b10010 : (e_kind == 2'd2) ? 5'b10000 :
                 (e_kind == 2'd3) ? 5'b00001 : 5'b00000;
        chk({v, " R7 exc_valid"}, 32'(exc), 32'(e_kind != 2'd0));
        chk({v, " R7 esr_store"}, 32'(store), 32'd0);
        chk({v, " R8 rf_we"}, 32'(we), 32'(e_kind == 2'd0 && e_rd != 5'd0));
        if (e_kind != 2'd0) begin
            chk({v, " R3 R4 R6 esr_cause"}, 32'(cause), 32'(ecause));
        end else if (e_rd != 5'd0) begin
            chk({v, " R8 rf_waddr"}, 32'(wa), 32'(e_rd));
            chk({v, " R8 rf_wdata"}, wd, mem_word(e_addr));
        end
        chk({v, " R5 msr_we"}, 32'(mwe), 32'(e_kind == 2'd1 || e_kind == 2'd2));
        if (e_kind == 2'd1 || e_kind == 2'd2) begin
            chk({v, " R5 saved modes"}, {30'd0, ums, vms}, {30'd0, e_um, e_vm});
            chk({v, " R5 live modes"}, {30'd0, um, vm}, 32'd0);
        end
        chk({v, " R6 esr_word"}, 32'(word), 32'(e_kind == 2'd3));
        if (e_kind == 2'd3)
            chk({v, " R6 esr_reg"}, 32'(ereg), 32'(e_rd));
        chk({v, " R4 esr_diz_we"}, 32'(dizwe), 32'(e_kind == 2'd2));
        if (e_kind == 2'd2)
            chk({v, " R4 esr_diz"}, 32'(diz), 32'd0);
    endtask

    task automatic issue_op(input logic [5:0] op, input logic [15:0] imm);
        @(negedge clk);
        issue_valid  = 1'b1;
        issue_opcode = op;
        issue_imm    = imm;
        @(posedge clk);
    endtask

    // One load; expected values derive from the requirements alone.
    task automatic run_load(input logic [31:0] ra, input logic [15:0] imm, input logic [4:0] rd,
                            input logic um, input logic vm, input logic hit, input logic prot,
                            input logic use_pfx, input logic [15:0] pfx);
        logic [15:0] hi;
        hi     = use_pfx ? pfx : {16{imm[15]}};
        e_addr = ra + {hi, imm};
        e_rd   = rd; e_um = um; e_vm = vm;
        if (vm && !hit)            e_kind = 2'd1;
        else if (prot && um && vm) e_kind = 2'd2;
        else if (e_addr[1:0] != 0) e_kind = 2'd3;
        else                       e_kind = 2'd0;
        if (use_pfx) issue_op(OP_PREFIX, pfx);
        @(negedge clk);
        issue_valid = 1'b1; issue_opcode = OP_LOAD; issue_imm = imm;
        issue_rd = rd; ra_value = ra;
        msr_um = um; msr_vm = vm; xlat_hit = hit; xlat_protect = prot;
        #1;
        chk("fast R1 R2 acc_addr", addr0, e_addr);
        chk("fast R10 R7 mem_req in issue cycle", 32'(req0), 32'(e_kind == 2'd0));
        chk("area R10 no mem_req in issue cycle", 32'(req1), 32'd0);
        @(posedge clk);
        @(negedge clk);
        issue_valid = 1'b0;
        check_result("fast", exc0, cause0, we0, waddr0, wdata0, mwe0, ums0, vms0, um0, vm0,
                     word0, ereg0, dizwe0, diz0, store0);
        chk("area R1 R2 acc_addr", addr1, e_addr);
        chk("area R10 R7 mem_req", 32'(req1), 32'(e_kind == 2'd0));
        chk("area R10 no early result", 32'(exc1 | we1), 32'd0);
        @(posedge clk);
        @(negedge clk);
        check_result("area", exc1, cause1, we1, waddr1, wdata1, mwe1, ums1, vms1, um1, vm1,
                     word1, ereg1, dizwe1, diz1, store1);
        chk("fast R7 exc_valid single pulse", 32'(exc0), 32'd0);
        msr_um = 1'b0; msr_vm = 1'b0; xlat_hit = 1'b1; xlat_protect = 1'b0;
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("reset R7 exc_valid", 32'(exc0 | exc1), 32'd0);
        chk("reset R8 rf_we", 32'(we0 | we1), 32'd0);
        chk("reset R10 mem_req", 32'(req0 | req1), 32'd0);
        chk("reset R5 msr_we", 32'(mwe0 | mwe1), 32'd0);
    endtask

    task automatic t_plain();        // R1 R8
        run_load(32'h0000_1000, 16'h0010, 5'd3, 0, 0, 1, 0, 0, 16'h0);
        run_load(32'h0000_1000, 16'hFFF0, 5'd7, 0, 0, 1, 0, 0, 16'h0);
        run_load(32'h8000_0004, 16'h7FFC, 5'd31, 1, 1, 1, 0, 0, 16'h0);
    endtask

    task automatic t_prefix();       // R2
        run_load(32'h0000_0100, 16'h8004, 5'd5, 0, 0, 1, 0, 1, 16'h1234);
        run_load(32'h0000_0100, 16'h8004, 5'd6, 0, 0, 1, 0, 0, 16'h0);
        issue_op(OP_PREFIX, 16'h4444);
        issue_op(6'b000000, 16'h0000);
        run_load(32'h0000_0200, 16'h0008, 5'd9, 0, 0, 1, 0, 0, 16'h0);
    endtask

    task automatic t_xlat();         // R3 R5
        run_load(32'h0000_2000, 16'h0000, 5'd4, 1, 1, 0, 1, 0, 16'h0);
        run_load(32'h0000_2001, 16'h0000, 5'd4, 0, 1, 0, 0, 0, 16'h0);
        run_load(32'h0000_2000, 16'h0004, 5'd8, 1, 0, 0, 0, 0, 16'h0);
    endtask

    task automatic t_prot();         // R4 R5
        run_load(32'h0000_3002, 16'h0000, 5'd10, 1, 1, 1, 1, 0, 16'h0);
        run_load(32'h0000_3000, 16'h0000, 5'd11, 0, 1, 1, 1, 0, 16'h0);
        run_load(32'h0000_3000, 16'h0000, 5'd12, 1, 0, 1, 1, 0, 16'h0);
    endtask

    task automatic t_align();        // R6 R7
        run_load(32'h0000_4000, 16'h0002, 5'd13, 0, 0, 1, 0, 0, 16'h0);
        run_load(32'h0000_4003, 16'h0000, 5'd14, 1, 1, 1, 0, 0, 16'h0);
    endtask

    task automatic t_reg0();         // R9
        run_load(32'h0000_5000, 16'h0000, 5'd0, 0, 0, 1, 0, 0, 16'h0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_plain();
        t_prefix();
        t_xlat();
        t_prot();
        t_align();
        t_reg0();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual running expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule